// File: doc/BRIEF.md
# Pulsed-Mode Bus Bit Codec

This block sits between a bit-level bus transmitter and a single-wire bus link that uses a pulsed line code, as found on optical or radio links. The bus has two levels: logic 0 is dominant and logic 1 is recessive. When one node drives dominant and another drives recessive in the same bit, the bus reads dominant.

On the transmit side, the block takes one bit per bit period. A dominant bit is sent as a low pulse that lasts exactly two prescaler ticks at the start of the period. A recessive bit leaves the line high for the whole period. On the receive side, the block does not sample the line level. It looks for a falling edge during each bit period: an edge means dominant, and no edge means recessive. Only one receive input is used. An optical or radio transceiver cannot hear its own signal, so the outgoing line is looped back inside the block and ANDed with the synchronised receive input.

Each transmitted bit is compared with the bit read back. If the node sends recessive and reads dominant, it has lost arbitration. It then stops driving for the rest of the frame, and a sticky flag records the loss until the next start of frame. The bit period is set as a number of prescaler ticks, with a floor of four ticks.

Top module: `pulse_bit_codec`

## Requirements
- R1: While reset is high and in the cycle after reset, `line_o` is 1, `arb_lost_o` is 0 and `rx_valid_o` is 0.
- R2: If the block is allowed to drive and samples `tx_bit_i` = 0 at a bit start, `line_o` goes low at that bit start. It returns high on the second tick after it, so the pulse lasts exactly 2 ticks.
- R3: If the block samples `tx_bit_i` = 1 at a bit start, `line_o` stays 1 for the whole bit period.
- R4: A bit period lasts max(`bit_len_i`, 4) ticks. `rx_valid_o` pulses for one cycle, one clock after each bit start, so it pulses once per period.
- R5: The bit reported with a `rx_valid_o` pulse is 0 if a falling edge was seen on the internal bus signal during the period that just ended, and 1 otherwise. The internal bus signal is the synchronised `rx_i` ANDed with `line_o`.
- R6: Loopback: the block's own dominant pulse is decoded as 0 even while `rx_i` stays high.
- R7: If the block sent recessive in a period and that period decodes as dominant, `arb_lost_o` rises together with that period's `rx_valid_o` pulse. From then on `line_o` stays 1, even for 0 bits at `tx_bit_i`.
- R8: `arb_lost_o` stays set until `sof_i` is asserted, and reads 0 in the cycle after `sof_i`. `sof_i` also restarts the bit timing: the next tick becomes a bit start, and `line_o` is 1 in the cycle after `sof_i`.
- R9: If `tx_en_i` is 0 when a bit start samples it, `line_o` stays 1 for that period, whatever `tx_bit_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaler tick, one clock wide |
| bit_len_i | input | CNT_W | Bit period in ticks; values below 4 act as 4 |
| sof_i | input | 1 | Start of frame: clears the arbitration flag and restarts the bit timing |
| tx_en_i | input | 1 | Node is transmitting this frame |
| tx_bit_i | input | 1 | Bit to send, sampled at each bit start |
| rx_i | input | 1 | Receive line (asynchronous) |
| line_o | output | 1 | Transmit line |
| rx_bit_o | output | 1 | Decoded bit of the period that just ended |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_bit_o` |
| arb_lost_o | output | 1 | Sticky flag: arbitration lost |

## Verification
Fixed bit sequences are sent at the minimum bit length, at a clamped length and at a long length. Each period is checked for its low-pulse width and its tick count. Some bits have the own node dominant with `rx_i` quiet, and others have `rx_i` pulsing while the node sends recessive. Comparing the two shows whether a decoded 0 came through the loopback or through the receive input. A frame with a recessive bit overridden from outside shows whether the node goes silent for its later dominant bits and whether the flag stays set until a new start of frame. Random frames, with rare outside pulses and random lengths, then mix all of these cases.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  // Dominant pulse width in prescaler ticks
  localparam int unsigned PULSE_TICKS   = 2;
  // Shortest legal bit period in prescaler ticks
  localparam int unsigned MIN_BIT_TICKS = 4;
endpackage

// File: rtl/pbc_bit_timer.sv
module pbc_bit_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             sof_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] phase_o,
  output logic             bound_o
);
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] last_w;

  assign last_w  = len_i - 1'b1;
  assign phase_o = phase_q;
  // A bit start is a tick that ends the previous period; sof has priority
  assign bound_o = tick_i && !sof_i && (phase_q >= last_w);

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= '0;
    else if (sof_i)
      phase_q <= last_w;
    else if (tick_i)
      phase_q <= bound_o ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/pbc_pulse_tx.sv
module pbc_pulse_tx
  import pbc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             sof_i,
  input  logic             bound_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             drive_ok_i,
  input  logic             tx_bit_i,
  output logic             line_o,
  output logic             sent_rec_o
);
  localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o     <= 1'b1;
      sent_rec_o <= 1'b0;
    end else if (sof_i) begin
      line_o     <= 1'b1;
      sent_rec_o <= 1'b0;
    end else if (bound_i) begin
      line_o     <= !(drive_ok_i && !tx_bit_i);
      sent_rec_o <= drive_ok_i && tx_bit_i;
    end else if (tick_i && phase_i == PULSE_END) begin
      line_o     <= 1'b1;
    end
  end
endmodule

// File: rtl/pbc_edge_rx.sv
module pbc_edge_rx #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  input  logic bound_i,
  input  logic rx_i,
  input  logic loop_i,
  output logic dec_o,
  output logic rx_bit_o,
  output logic rx_valid_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   bus_w;
  logic                   prev_q;
  logic                   seen_q;
  logic                   fall_w;

  // Wired-AND of the far line with the looped-back own line
  assign bus_w  = sync_q[SYNC_STAGES-1] & loop_i;
  assign fall_w = prev_q & ~bus_w;
  assign dec_o  = !(seen_q || fall_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '1;
      prev_q     <= 1'b1;
      seen_q     <= 1'b0;
      rx_bit_o   <= 1'b1;
      rx_valid_o <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], rx_i};
      prev_q     <= bus_w;
      rx_valid_o <= bound_i;
      if (bound_i) begin
        rx_bit_o <= dec_o;
        seen_q   <= 1'b0;
      end else if (sof_i) begin
        seen_q   <= 1'b0;
      end else if (fall_w) begin
        seen_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbc_arb_track.sv
module pbc_arb_track (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  input  logic bound_i,
  input  logic sent_rec_i,
  input  logic dec_i,
  output logic lose_now_o,
  output logic lost_o
);
  assign lose_now_o = bound_i && sent_rec_i && !dec_i;

  always_ff @(posedge clk) begin
    if (rst)
      lost_o <= 1'b0;
    else if (sof_i)
      lost_o <= 1'b0;
    else if (lose_now_o)
      lost_o <= 1'b1;
  end
endmodule

// File: rtl/pulse_bit_codec.sv
module pulse_bit_codec
  import pbc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] bit_len_i,
  input  logic             sof_i,
  input  logic             tx_en_i,
  input  logic             tx_bit_i,
  input  logic             rx_i,
  output logic             line_o,
  output logic             rx_bit_o,
  output logic             rx_valid_o,
  output logic             arb_lost_o
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_BIT_TICKS);

  logic [CNT_W-1:0] len_eff;
  logic [CNT_W-1:0] phase;
  logic             bound;
  logic             sent_rec;
  logic             dec;
  logic             lose_now;
  logic             drive_ok;

  assign len_eff  = (bit_len_i < MIN_LEN) ? MIN_LEN : bit_len_i;
  assign drive_ok = tx_en_i && !arb_lost_o && !lose_now;

  pbc_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .sof_i(sof_i),
    .len_i(len_eff), .phase_o(phase), .bound_o(bound)
  );

  pbc_pulse_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .tick_i(tick_i), .sof_i(sof_i),
    .bound_i(bound), .phase_i(phase), .drive_ok_i(drive_ok),
    .tx_bit_i(tx_bit_i), .line_o(line_o), .sent_rec_o(sent_rec)
  );

  pbc_edge_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .sof_i(sof_i), .bound_i(bound),
    .rx_i(rx_i), .loop_i(line_o), .dec_o(dec),
    .rx_bit_o(rx_bit_o), .rx_valid_o(rx_valid_o)
  );

  pbc_arb_track u_arb (
    .clk(clk), .rst(rst), .sof_i(sof_i), .bound_i(bound),
    .sent_rec_i(sent_rec), .dec_i(dec),
    .lose_now_o(lose_now), .lost_o(arb_lost_o)
  );
endmodule

// File: rtl/pbc_checker.sv
module pbc_checker (
  input logic clk,
  input logic rst,
  input logic sof_i,
  input logic line_o,
  input logic rx_valid_o,
  input logic arb_lost_o
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (line_o && !arb_lost_o && !rx_valid_o));

  assert_valid_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  assert_silent_after_loss_R7: assert property (@(posedge clk) disable iff (rst)
    arb_lost_o |-> line_o);

  assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (arb_lost_o && !sof_i) |=> arb_lost_o);

  assert_sof_clears_R8: assert property (@(posedge clk) disable iff (rst)
    sof_i |=> (!arb_lost_o && line_o));
endmodule

bind pulse_bit_codec pbc_checker u_pbc_checker (
  .clk(clk), .rst(rst), .sof_i(sof_i), .line_o(line_o),
  .rx_valid_o(rx_valid_o), .arb_lost_o(arb_lost_o)
);

// File: tb/pulse_bit_codec_test.sv
`timescale 1ns/1ps
module pulse_bit_codec_test;
  localparam int TP = 3;  // clocks per prescaler tick

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick;
  logic [7:0] bit_len = 8'd4;
  logic       sof = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_bit = 1'b1;
  logic       rx = 1'b1;
  logic       line_o, rx_bit_o, rx_valid_o, arb_lost_o;

  int total = 0;
  int bad = 0;
  int tdiv = 0;
  int since = 0, lowc = 0, per_clks = 0, per_low = 0;
  bit bits [0:31];
  bit oth  [0:31];
  bit lost_m;

  always #4 clk = ~clk;

  pulse_bit_codec uut (
    .clk(clk), .rst(rst), .tick_i(tick), .bit_len_i(bit_len),
    .sof_i(sof), .tx_en_i(tx_en), .tx_bit_i(tx_bit), .rx_i(rx),
    .line_o(line_o), .rx_bit_o(rx_bit_o), .rx_valid_o(rx_valid_o),
    .arb_lost_o(arb_lost_o)
  );

  always @(posedge clk) begin
    if (rst) tdiv <= 0;
    else tdiv <= (tdiv == TP - 1) ? 0 : tdiv + 1;
  end
  assign tick = !rst && (tdiv == TP - 1);

  // Period monitor: clocks per period and low clocks per period
  always @(negedge clk) begin
    if (rx_valid_o) begin
      per_clks = since;
      per_low  = lowc;
      since    = 1;
      lowc     = line_o ? 0 : 1;
    end else begin
      since = since + 1;
      lowc  = lowc + (line_o ? 0 : 1);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    bit got = 0;
    while (!got) begin
      @(negedge clk); #1;
      got = rx_valid_o;
    end
  endtask

  function automatic int eff_len(input int len);
    return (len < 4) ? 4 : len;
  endfunction

  task automatic start_frame(input int len, input bit en);
    bit_len = 8'(len);
    tx_en   = en;
    tx_bit  = bits[0];
    rx      = 1'b1;
    @(negedge clk); #1;
    sof = 1'b1;
    @(negedge clk); #1;
    sof = 1'b0;
    chk(line_o == 1'b1, "R8 line high after sof", int'(line_o), 1);
    chk(arb_lost_o == 1'b0, "R8 flag cleared by sof", int'(arb_lost_o), 0);
    lost_m = 0;
    wait_valid();  // first bit start of the frame
  endtask

  task automatic run_bits(input int n, input int len, input bit en);
    for (int k = 0; k < n; k++) begin
      bit active, own_dom, bus_dom;
      int exp_low;
      tx_bit = (k + 1 < n) ? bits[k+1] : 1'b1;
      if (oth[k]) begin
        rx = 1'b0;
        repeat (2 * TP) @(negedge clk);
        #1 rx = 1'b1;
      end
      wait_valid();
      active  = en && !lost_m;
      own_dom = active && !bits[k];
      bus_dom = own_dom || oth[k];
      if (active && bits[k] && oth[k]) lost_m = 1;
      exp_low = own_dom ? 2 * TP : 0;
      if (own_dom && !oth[k])
        chk(rx_bit_o == 1'b0, "R6 loopback decode", int'(rx_bit_o), 0);
      else
        chk(rx_bit_o == !bus_dom, "R5 edge decode", int'(rx_bit_o), int'(!bus_dom));
      if (!en)
        chk(per_low == 0, "R9 disabled line high", per_low, 0);
      else if (lost_m && !bits[k])
        chk(per_low == 0, "R7 silent after loss", per_low, 0);
      else if (own_dom)
        chk(per_low == exp_low, "R2 pulse width", per_low, exp_low);
      else
        chk(per_low == 0, "R3 recessive high", per_low, 0);
      chk(per_clks == eff_len(len) * TP, "R4 period length", per_clks, eff_len(len) * TP);
      chk(arb_lost_o == lost_m, "R7 arbitration flag", int'(arb_lost_o), int'(lost_m));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(line_o == 1'b1, "R1 reset line", int'(line_o), 1);
    chk(arb_lost_o == 1'b0, "R1 reset flag", int'(arb_lost_o), 0);
    chk(rx_valid_o == 1'b0, "R1 reset valid", int'(rx_valid_o), 0);

    // Frame A: minimum length, own bits only
    for (int i = 0; i < 32; i++) begin bits[i] = 1'b1; oth[i] = 1'b0; end
    bits[0] = 0; bits[2] = 0; bits[3] = 0;
    start_frame(4, 1'b1);
    run_bits(6, 4, 1'b1);

    // Frame B: clamped length, outside pulses on recessive-free bits
    for (int i = 0; i < 32; i++) begin bits[i] = 1'b0; oth[i] = 1'b0; end
    oth[1] = 1; oth[3] = 1;
    start_frame(2, 1'b1);
    run_bits(5, 2, 1'b1);

    // Frame C: long length, arbitration lost at bit 1, later zeros not driven
    for (int i = 0; i < 32; i++) begin bits[i] = 1'b0; oth[i] = 1'b0; end
    bits[0] = 1; bits[1] = 1; oth[1] = 1; bits[4] = 1; oth[5] = 1;
    start_frame(9, 1'b1);
    run_bits(7, 9, 1'b1);
    // Flag stays set with no sof, node stays silent
    tx_bit = 1'b0;
    wait_valid();
    wait_valid();
    chk(arb_lost_o == 1'b1, "R8 flag sticky", int'(arb_lost_o), 1);
    chk(per_low == 0, "R7 silent while flagged", per_low, 0);

    // Frame D: transmitter disabled, zeros at tx_bit
    for (int i = 0; i < 32; i++) begin bits[i] = 1'b0; oth[i] = (i == 2); end
    start_frame(5, 1'b0);
    run_bits(4, 5, 1'b0);

    // Random frames
    for (int f = 0; f < 6; f++) begin
      int len;
      len = 4 + int'($urandom % 8);
      for (int i = 0; i < 32; i++) begin
        bits[i] = 1'($urandom % 2);
        oth[i]  = (($urandom % 8) == 0);
      end
      start_frame(len, 1'b1);
      run_bits(12, len, 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule